// File: doc/BRIEF.md
# Four-Level Page Walker with Block Fragments

This block resolves a 48-bit virtual address into its leaf translation entry by walking a four-level table tree: two upper directory levels (the 512 GiB and 1 GiB directories), a lowest directory level, and a final table of 4 KiB entries. A walk starts when a request carrying the virtual address and the byte address of the root table is accepted. The walker reads one 64-bit entry per level through a memory read port, decodes it, and either computes the next entry address or stops and presents the result: the leaf entry, a page-size code and two flags.

A walk may stop early. A directory entry with its leaf bit set is itself the leaf, and the page size follows from the level where it was found. The walker also supports a mixed-page mode. A directory entry can carry a non-zero block-fragment size. Once seen, that size is remembered for the rest of the walk. At the lowest directory level the entry is then treated as a 2 MiB leaf unless its further-walk bit is set. If that bit is set, the index into the final table is a field of the virtual address whose width and position come from the fragment sizes.

All three interfaces are valid/ready streams with one exception. The request is taken when `req_valid` and `req_ready` are both high, and `req_ready` is high only while the walker is idle. A memory read is issued when `mem_req_valid` and `mem_req_ready` are both high. The walker holds the valid signal and the address unchanged while the memory side stalls. The read response has no ready: the walker waits in a state where it always takes `mem_rsp_valid`. The result is held, unchanged, until `res_ready` is high. Only one read is in flight at any time.

Top module: `frag_walker`

## Requirements
- R1: The first read after a request targets the root table using virtual-address bits [47:39] as the index. Each following read moves down one level and uses bits [38:30], then [29:21], then [20:12]. No walk issues more than four reads.
- R2: Each entry has this layout: valid at bit 0, leaf at bit 54, further-walk at bit 55, block-fragment size at bits [63:59], and the table base in the remaining upper bits. The next read address is (((entry >> 6) << 3) + index) << 3, truncated to 48 bits. The root address goes through the same formula.
- R3: A valid directory entry with the leaf bit set ends the walk and is returned. The size code is 3 (512 GiB) at the root level, 2 (1 GiB) at the second level and 1 (2 MiB) at the lowest directory level. A final-table entry always ends the walk, with code 0 (4 KiB).
- R4: A non-zero fragment size in any directory entry is latched and stays in force for the rest of the walk, including lower levels that carry zero. The latched value is cleared when a new walk starts.
- R5: At the lowest directory level, the entry is returned as a 2 MiB leaf when the leaf bit is clear, the fragment size in force is non-zero and the further-walk bit is clear.
- R6: When a lowest-level directory entry has the further-walk bit set, the index into the final table is a field of the virtual address. Its width is the fragment size in force, and it starts at bit 12 plus the fragment size carried by that entry.
- R7: A valid directory entry whose fragment size is neither 0 nor 9 ends the walk at once, with `res_err` set and no further read.
- R8: An entry with the valid bit clear ends the walk with `res_fault` set and `res_err` clear, and the walker issues no further read.
- R9: While a read request is stalled, `mem_req_valid` stays high with a stable address. No new read is issued until the response to the previous one has arrived.
- R10: While `res_valid` is high and `res_ready` is low, all result outputs hold steady. `req_ready` is low from acceptance until the result is taken.
- R11: After reset the walker is idle: `req_ready` is high, and `mem_req_valid` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_root | input | PA_W | Byte address of the root table |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid (always accepted) |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | Walk result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_entry | output | 64 | Leaf entry, or the entry that ended the walk |
| res_size | output | 2 | Page-size code: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB, 3 = 512 GiB |
| res_fault | output | 1 | Walk ended on an invalid entry |
| res_err | output | 1 | Walk ended on an illegal fragment size |

## Verification
Most internal faults show at the memory port before any result appears. A wrong level register, a stale fragment value or a wrong index selection changes the address of the very next read, which is visible on `mem_req_addr` one cycle after the response that caused it. It also changes the number of reads per walk. A fragment value that is not cleared between walks shows up one walk later, as a premature 2 MiB leaf at the lowest directory level. For that reason the directed scenarios are ordered so that a fragmented walk is followed by a plain one. The result hold and the single-outstanding-read rule are checked in every cycle, so a handshake fault is flagged in the cycle it occurs.

// File: rtl/frag_walker_pkg.sv
package frag_walker_pkg;

  // Entry geometry
  localparam int ENTRY_W     = 64;
  localparam int VALID_BIT   = 0;
  localparam int LEAF_BIT    = 54;
  localparam int FURTHER_BIT = 55;
  localparam int BFS_LSB     = 59;
  localparam int BFS_W       = 5;

  // Table level being read; numeric value equals the level's index slot
  typedef enum logic [1:0] {
    LVL_PTE  = 2'd0,
    LVL_PDE0 = 2'd1,
    LVL_PDE1 = 2'd2,
    LVL_PDE2 = 2'd3
  } walk_level_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_2M   = 2'd1,
    PG_1G   = 2'd2,
    PG_512G = 2'd3
  } page_size_e;

endpackage

// File: rtl/frag_walker_index.sv
// Selects the table index out of the virtual address: a fixed-width slot per
// level, or a fragment-controlled field for the final-table step.
module frag_walker_index #(
  parameter int VA_W       = 48,
  parameter int LVL_BITS   = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int BFS_W      = 5,
  parameter int LEVELS     = 4
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [1:0]       level,
  input  logic             use_frag,
  input  logic [BFS_W-1:0] frag_width,
  input  logic [BFS_W-1:0] frag_shift,
  output logic [VA_W-1:0]  idx
);
  localparam int SH_W = 8;
  localparam logic [VA_W-1:0] LVL_MASK = VA_W'((64'd1 << LVL_BITS) - 64'd1);

  logic [VA_W-1:0] lvl_idx [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_slot
    localparam int SLOT_LSB = PAGE_SHIFT + g * LVL_BITS;
    assign lvl_idx[g] = (vaddr >> SLOT_LSB) & LVL_MASK;
  end

  logic [SH_W-1:0] frag_sh;
  logic [VA_W-1:0] frag_mask;

  always_comb begin
    frag_sh   = SH_W'(PAGE_SHIFT) + SH_W'(frag_shift);
    frag_mask = ~({VA_W{1'b1}} << frag_width);
    if (use_frag) idx = (vaddr >> frag_sh) & frag_mask;
    else          idx = lvl_idx[level];
  end

endmodule

// File: rtl/frag_walker_addr.sv
// Next entry address from a table word and an index.
module frag_walker_addr #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 48,
  parameter int ENTRY_W = 64
) (
  input  logic [ENTRY_W-1:0] table_word,
  input  logic [VA_W-1:0]    idx,
  output logic [PA_W-1:0]    addr
);
  logic [ENTRY_W-1:0] qword_addr;
  logic [ENTRY_W-1:0] byte_addr;

  always_comb begin
    qword_addr = ((table_word >> 6) << 3) + ENTRY_W'(idx);
    byte_addr  = qword_addr << 3;
    addr       = byte_addr[PA_W-1:0];
  end

endmodule

// File: rtl/frag_walker_decode.sv
// Classifies one fetched entry at a given level.
module frag_walker_decode
  import frag_walker_pkg::*;
#(
  parameter int LEGAL_BFS = 9
) (
  input  walk_level_e      level,
  input  logic             ent_valid,
  input  logic             ent_leaf,
  input  logic             ent_further,
  input  logic [BFS_W-1:0] ent_bfs,
  input  logic [BFS_W-1:0] latched_bfs,
  output logic             leaf,
  output logic             fault,
  output logic             err,
  output logic             use_frag,
  output page_size_e       size,
  output logic [BFS_W-1:0] eff_bfs
);
  logic is_dir;
  logic bfs_seen;

  always_comb begin
    is_dir   = (level != LVL_PTE);
    bfs_seen = is_dir && (ent_bfs != '0);
    eff_bfs  = bfs_seen ? ent_bfs : latched_bfs;

    fault    = !ent_valid;
    err      = ent_valid && bfs_seen && (ent_bfs != BFS_W'(LEGAL_BFS));
    use_frag = (level == LVL_PDE0) && ent_further;

    unique case (level)
      LVL_PTE: begin
        leaf = 1'b1;
        size = PG_4K;
      end
      LVL_PDE0: begin
        leaf = ent_leaf || ((eff_bfs != '0) && !ent_further);
        size = PG_2M;
      end
      LVL_PDE1: begin
        leaf = ent_leaf;
        size = PG_1G;
      end
      default: begin
        leaf = ent_leaf;
        size = PG_512G;
      end
    endcase
  end

endmodule

// File: rtl/frag_walker.sv
module frag_walker
  import frag_walker_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 48,
  parameter int LVL_BITS   = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int LEGAL_BFS  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [PA_W-1:0]    req_root,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [ENTRY_W-1:0] res_entry,
  output logic [1:0]         res_size,
  output logic               res_fault,
  output logic               res_err
);
  localparam int LEVELS = 4;

  walk_state_e        state_q;
  walk_level_e        level_q;
  walk_level_e        next_level;
  logic [VA_W-1:0]    vaddr_q;
  logic [PA_W-1:0]    addr_q;
  logic [BFS_W-1:0]   bfs_q;
  logic [ENTRY_W-1:0] res_entry_q;
  page_size_e         res_size_q;
  logic               res_fault_q;
  logic               res_err_q;

  // Entry decode
  logic             dec_leaf, dec_fault, dec_err, dec_use_frag;
  page_size_e       dec_size;
  logic [BFS_W-1:0] dec_eff_bfs;
  logic [BFS_W-1:0] ent_bfs;

  assign ent_bfs = mem_rsp_data[BFS_LSB +: BFS_W];

  frag_walker_decode #(
    .LEGAL_BFS (LEGAL_BFS)
  ) u_decode (
    .level       (level_q),
    .ent_valid   (mem_rsp_data[VALID_BIT]),
    .ent_leaf    (mem_rsp_data[LEAF_BIT]),
    .ent_further (mem_rsp_data[FURTHER_BIT]),
    .ent_bfs     (ent_bfs),
    .latched_bfs (bfs_q),
    .leaf        (dec_leaf),
    .fault       (dec_fault),
    .err         (dec_err),
    .use_frag    (dec_use_frag),
    .size        (dec_size),
    .eff_bfs     (dec_eff_bfs)
  );

  always_comb begin
    unique case (level_q)
      LVL_PDE2: next_level = LVL_PDE1;
      LVL_PDE1: next_level = LVL_PDE0;
      default:  next_level = LVL_PTE;
    endcase
  end

  // One index/address path serves both the root read and every later read
  logic               in_idle;
  logic [VA_W-1:0]    idx_vaddr;
  logic [1:0]         idx_level;
  logic               idx_frag;
  logic [VA_W-1:0]    idx;
  logic [ENTRY_W-1:0] tbl_word;
  logic [PA_W-1:0]    nxt_addr;

  always_comb begin
    in_idle   = (state_q == ST_IDLE);
    idx_vaddr = in_idle ? req_vaddr : vaddr_q;
    idx_level = in_idle ? 2'(LVL_PDE2) : 2'(next_level);
    idx_frag  = (state_q == ST_WAIT) && dec_use_frag;
    tbl_word  = in_idle ? ENTRY_W'(req_root) : mem_rsp_data;
  end

  frag_walker_index #(
    .VA_W       (VA_W),
    .LVL_BITS   (LVL_BITS),
    .PAGE_SHIFT (PAGE_SHIFT),
    .BFS_W      (BFS_W),
    .LEVELS     (LEVELS)
  ) u_index (
    .vaddr      (idx_vaddr),
    .level      (idx_level),
    .use_frag   (idx_frag),
    .frag_width (dec_eff_bfs),
    .frag_shift (ent_bfs),
    .idx        (idx)
  );

  frag_walker_addr #(
    .VA_W    (VA_W),
    .PA_W    (PA_W),
    .ENTRY_W (ENTRY_W)
  ) u_addr (
    .table_word (tbl_word),
    .idx        (idx),
    .addr       (nxt_addr)
  );

  logic walk_ends;
  assign walk_ends = dec_fault || dec_err || dec_leaf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      level_q     <= LVL_PDE2;
      vaddr_q     <= '0;
      addr_q      <= '0;
      bfs_q       <= '0;
      res_entry_q <= '0;
      res_size_q  <= PG_4K;
      res_fault_q <= 1'b0;
      res_err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            addr_q  <= nxt_addr;
            level_q <= LVL_PDE2;
            bfs_q   <= '0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (walk_ends) begin
              res_entry_q <= mem_rsp_data;
              res_size_q  <= dec_size;
              res_fault_q <= dec_fault;
              res_err_q   <= dec_err;
              state_q     <= ST_DONE;
            end else begin
              addr_q  <= nxt_addr;
              level_q <= next_level;
              bfs_q   <= dec_eff_bfs;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: begin
          if (res_ready) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = addr_q;
  assign res_valid     = (state_q == ST_DONE);
  assign res_entry     = res_entry_q;
  assign res_size      = res_size_q;
  assign res_fault     = res_fault_q;
  assign res_err       = res_err_q;

endmodule

// File: rtl/frag_walker_chk.sv
module frag_walker_chk #(
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            res_valid,
  input logic            res_ready,
  input logic [63:0]     res_entry,
  input logic [1:0]      res_size,
  input logic            res_fault,
  input logic            res_err
);
  logic       outstanding;
  logic [2:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      rd_cnt      <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
      else if (mem_rsp_valid)             outstanding <= 1'b0;
      if (req_valid && req_ready)              rd_cnt <= '0;
      else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 3'd1;
    end
  end

  assert_reads_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |-> (rd_cnt < 3'd4));

  assert_fault_not_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_fault && res_err));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mem_req_valid);

  assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_entry) && $stable(res_size)
                                   && $stable(res_fault) && $stable(res_err)));

  assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!res_valid && !mem_req_valid));

endmodule

bind frag_walker frag_walker_chk #(.PA_W(PA_W)) u_frag_walker_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_entry     (res_entry),
  .res_size      (res_size),
  .res_fault     (res_fault),
  .res_err       (res_err)
);

// File: tb/frag_walker_bench.sv
`timescale 1ns/1ps
module frag_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic [47:0] req_root = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [63:0] res_entry;
  logic [1:0]  res_size;
  logic        res_fault;
  logic        res_err;

  always #4 clk = ~clk;

  frag_walker u_frag_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_entry(res_entry), .res_size(res_size),
    .res_fault(res_fault), .res_err(res_err)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // ---------------- memory model ----------------
  logic [47:0] mem_a [16];
  logic [63:0] mem_d [16];
  int          mem_n = 0;
  logic        stall = 1'b0;
  logic [47:0] rd_log [128];
  int          rd_total = 0;
  logic        pend = 1'b0;
  logic [63:0] pend_d = '0;

  function automatic logic [63:0] lookup(input logic [47:0] a);
    for (int i = 0; i < 16; i++)
      if (i < mem_n && mem_a[i] == a) return mem_d[i];
    return 64'd0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    #2;
    mem_rsp_valid = pend;
    mem_rsp_data  = pend_d;
    pend = 1'b0;
    mem_req_ready = !stall;
    if (mem_req_valid && mem_req_ready) begin
      pend   = 1'b1;
      pend_d = lookup(mem_req_addr);
      rd_log[rd_total % 128] = mem_req_addr;
      rd_total++;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [47:0] nxt(input logic [63:0] w, input logic [63:0] idx);
    logic [63:0] t;
    t = (((w >> 6) << 3) + idx) << 3;
    return t[47:0];
  endfunction

  function automatic logic [63:0] ix(input logic [47:0] va, input int lsb, input int width);
    return (64'(va) >> lsb) & ((64'd1 << width) - 64'd1);
  endfunction

  function automatic logic [63:0] mk(input logic [47:0] base, input bit v, input bit p,
                                     input bit f, input logic [4:0] bfs);
    logic [63:0] e;
    e = 64'(base) & ~64'h3F;
    e[0] = v; e[54] = p; e[55] = f; e[63:59] = bfs;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mem_put(input logic [47:0] a, input logic [63:0] d);
    mem_a[mem_n] = a; mem_d[mem_n] = d; mem_n++;
  endtask

  localparam logic [47:0] ROOT = 48'h0000_0010_0000;
  localparam logic [47:0] T1   = 48'h0000_0020_0000;
  localparam logic [47:0] T0   = 48'h0000_0030_0000;
  localparam logic [47:0] TP   = 48'h0000_0040_0000;
  localparam logic [47:0] PG   = 48'h0000_5000_0000;
  localparam logic [47:0] VA   = 48'h0123_5A5A_3000;

  logic [47:0] a2, a1, a0, ap;

  // Places a chain of four entries; pidx is the final-table index.
  task automatic chain(input logic [63:0] e2, input logic [63:0] e1, input logic [63:0] e0,
                       input logic [63:0] ep, input logic [63:0] pidx);
    mem_n = 0;
    a2 = nxt(64'(ROOT), ix(VA, 39, 9));
    a1 = nxt(e2, ix(VA, 30, 9));
    a0 = nxt(e1, ix(VA, 21, 9));
    ap = nxt(e0, pidx);
    mem_put(a2, e2); mem_put(a1, e1); mem_put(a0, e0); mem_put(ap, ep);
  endtask

  logic [63:0] r_e; logic [1:0] r_sz; logic r_f, r_er; int r_n, r_b;

  task automatic run_walk(input int hold);
    int w;
    @(negedge clk);
    r_b = rd_total;
    req_vaddr = VA; req_root = ROOT; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!res_valid && w < 200) begin
      @(negedge clk);
      w++;
    end
    chk(res_valid, "R1 walk completes", 64'(res_valid), 64'd1);
    r_e = res_entry; r_sz = res_size; r_f = res_fault; r_er = res_err;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(res_valid && res_entry == r_e && res_size == r_sz && res_fault == r_f
          && res_err == r_er && !req_ready, "R10 result held", res_entry, r_e);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    r_n = rd_total - r_b;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(req_ready === 1'b1, "R11 req_ready", 64'(req_ready), 64'd1);
    chk(mem_req_valid === 1'b0, "R11 mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk(res_valid === 1'b0, "R11 res_valid", 64'(res_valid), 64'd0);
  endtask

  task automatic t_full_walk();
    logic [63:0] ep;
    ep = mk(PG, 1, 0, 0, 0);
    chain(mk(T1, 1, 0, 0, 0), mk(T0, 1, 0, 0, 0), mk(TP, 1, 0, 0, 0), ep, ix(VA, 12, 9));
    run_walk(0);
    chk(r_n == 4, "R1 read count", 64'(r_n), 64'd4);
    chk(rd_log[r_b % 128] == a2, "R1 R2 root read", 64'(rd_log[r_b % 128]), 64'(a2));
    chk(rd_log[(r_b+1) % 128] == a1, "R1 R2 second read", 64'(rd_log[(r_b+1) % 128]), 64'(a1));
    chk(rd_log[(r_b+2) % 128] == a0, "R1 R2 third read", 64'(rd_log[(r_b+2) % 128]), 64'(a0));
    chk(rd_log[(r_b+3) % 128] == ap, "R1 R2 final read", 64'(rd_log[(r_b+3) % 128]), 64'(ap));
    chk(r_e == ep && r_sz == 2'd0 && !r_f && !r_er, "R3 4K leaf", r_e, ep);
  endtask

  task automatic t_leaf_levels();
    logic [63:0] e;
    e = mk(T1, 1, 1, 0, 0);
    chain(e, mk(T0, 1, 0, 0, 0), mk(TP, 1, 0, 0, 0), mk(PG, 1, 0, 0, 0), ix(VA, 12, 9));
    run_walk(0);
    chk(r_n == 1 && r_sz == 2'd3 && r_e == e, "R3 root leaf 512G", 64'(r_sz), 64'd3);
    e = mk(T0, 1, 1, 0, 0);
    chain(mk(T1, 1, 0, 0, 0), e, mk(TP, 1, 0, 0, 0), mk(PG, 1, 0, 0, 0), ix(VA, 12, 9));
    run_walk(0);
    chk(r_n == 2 && r_sz == 2'd2 && r_e == e, "R3 second-level leaf 1G", 64'(r_sz), 64'd2);
    e = mk(TP, 1, 1, 0, 0);
    chain(mk(T1, 1, 0, 0, 0), mk(T0, 1, 0, 0, 0), e, mk(PG, 1, 0, 0, 0), ix(VA, 12, 9));
    run_walk(0);
    chk(r_n == 3 && r_sz == 2'd1 && r_e == e, "R3 lowest-dir leaf 2M", 64'(r_sz), 64'd1);
  endtask

  task automatic t_frag_leaf();
    logic [63:0] e;
    e = mk(TP, 1, 0, 0, 0);
    chain(mk(T1, 1, 0, 0, 0), mk(T0, 1, 0, 0, 9), e, mk(PG, 1, 0, 0, 0), ix(VA, 12, 9));
    run_walk(0);
    chk(r_n == 3 && r_sz == 2'd1 && r_e == e && !r_er, "R5 fragment leaf at lowest dir",
        64'(r_n), 64'd3);
    // fragment latched at the root persists through a plain second level
    chain(mk(T1, 1, 0, 0, 9), mk(T0, 1, 0, 0, 0), e, mk(PG, 1, 0, 0, 0), ix(VA, 12, 9));
    run_walk(0);
    chk(r_n == 3 && r_sz == 2'd1, "R4 fragment held across levels", 64'(r_n), 64'd3);
  endtask

  task automatic t_frag_further();
    logic [63:0] ep;
    ep = mk(PG, 1, 0, 0, 0);
    chain(mk(T1, 1, 0, 0, 0), mk(T0, 1, 0, 0, 9), mk(TP, 1, 0, 1, 9), ep, ix(VA, 21, 9));
    run_walk(0);
    chk(r_n == 4, "R6 further walk read count", 64'(r_n), 64'd4);
    chk(rd_log[(r_b+3) % 128] == ap, "R6 fragment-selected index",
        64'(rd_log[(r_b+3) % 128]), 64'(ap));
    chk(r_e == ep && r_sz == 2'd0, "R6 final leaf", r_e, ep);
  endtask

  task automatic t_latch_cleared();
    chain(mk(T1, 1, 0, 0, 0), mk(T0, 1, 0, 0, 0), mk(TP, 1, 0, 0, 0), mk(PG, 1, 0, 0, 0),
          ix(VA, 12, 9));
    run_walk(0);
    chk(r_n == 4 && r_sz == 2'd0, "R4 fragment cleared at new walk", 64'(r_n), 64'd4);
  endtask

  task automatic t_illegal();
    logic [63:0] e;
    e = mk(T0, 1, 0, 0, 5);
    chain(mk(T1, 1, 0, 0, 0), e, mk(TP, 1, 0, 0, 0), mk(PG, 1, 0, 0, 0), ix(VA, 12, 9));
    run_walk(0);
    chk(r_er && !r_f && r_n == 2 && r_e == e, "R7 illegal fragment size", 64'(r_n), 64'd2);
  endtask

  task automatic t_fault();
    chain(mk(T1, 1, 0, 0, 0), mk(T0, 1, 0, 0, 0), mk(TP, 0, 1, 0, 0), mk(PG, 1, 0, 0, 0),
          ix(VA, 12, 9));
    run_walk(0);
    chk(r_f && !r_er && r_n == 3, "R8 invalid entry fault", 64'(r_n), 64'd3);
  endtask

  task automatic t_backpressure();
    int base;
    chain(mk(T1, 1, 0, 0, 0), mk(T0, 1, 0, 0, 0), mk(TP, 1, 0, 0, 0), mk(PG, 1, 0, 0, 0),
          ix(VA, 12, 9));
    @(negedge clk);
    stall = 1'b1;
    base = rd_total;
    req_vaddr = VA; req_root = ROOT; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(mem_req_valid && mem_req_addr == a2, "R9 stalled request held",
        64'(mem_req_addr), 64'(a2));
    chk(!req_ready, "R10 busy during walk", 64'(req_ready), 64'd0);
    chk(rd_total == base, "R9 no read while stalled", 64'(rd_total - base), 64'd0);
    stall = 1'b0;
    begin
      int w;
      w = 0;
      while (!res_valid && w < 200) begin
        @(negedge clk);
        w++;
      end
    end
    r_e = res_entry;
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk(res_valid && res_entry == r_e && !req_ready, "R10 result held", res_entry, r_e);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(rd_total - base == 4, "R9 one read per level", 64'(rd_total - base), 64'd4);
    chk(req_ready, "R10 idle after result taken", 64'(req_ready), 64'd1);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_walk();
    t_leaf_levels();
    t_frag_leaf();
    t_frag_further();
    t_latch_cleared();
    t_illegal();
    t_fault();
    t_backpressure();
    run_walk(2);
    chk(r_n == 4, "R10 walk after hold", 64'(r_n), 64'd4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule